// File: doc/BRIEF.md
# Channel Command Decoder with Write Protection

This block sits on a shared 16-bit command channel and serves one peripheral. It watches for a strobe while the channel says the word is meant for a peripheral. It compares a four-bit equipment field of the command word with a static equipment setting. When both match, it captures the command and answers. The answer is a one-clock reply, or a one-clock reject, a fixed delay after capture. The delay is equal to 400 ns and is counted in clock cycles.

The low six bits of a captured command set the scan mode, start or stop scanning, and gate the periodic word interrupt. They also clear or load the terminal address and clear the lockout. A status request returns an 11-bit status word. A protect switch limits what unprotected commands may do.

The block holds the pending interrupt conditions and the interrupt line. It also keeps a lockout flag that stops repeated acknowledge-failure interrupts. The scanning datapath and the memory port are not part of the block. They appear only as status inputs, event pulses and control outputs.

Top module: `chan_cmd_top`

## Requirements
- R1: A command is captured only when `wzero_i` is 1, `cmd_i[10:7]` equals `eq_num_i`, and `strb_in_i` or `strb_out_i` is 1. Any other combination gives neither reply nor reject and changes no state.
- R2: Each captured command gives exactly one answer, on `reply_o` or on `reject_o`, never both. The answer is one clock wide and first appears REPLY_CYC clock edges after the capture edge. REPLY_CYC is 400 ns divided by the clock period, rounded up, which is 80 at 5 ns. Strobes that arrive while an answer is pending are ignored.
- R3: When bit0 is 1, bits 4, 3 and 2 each act on their own. Bit 4 sets `scan_dual_o` to bit1. Bit 3 sets `scan_run_o` to the inverse of bit1, so 1 means stop. Bit 2 sets `word_irq_en_o` to the inverse of bit1, so 1 means disable.
- R4: Command bits 5..0 equal to 000001 are a plain status request. `status_o` is loaded with the status word in the cycle of the reply. From bit 10 down to bit 0 the word is: protect fault, lockout, `eop_i`, `dual_est_i`, `peer_idle_i`, `peer_fail_i`, `self_fail_i`, terminal interrupt pending, word interrupt pending, `busy_i`, and the interrupt line.
- R5: Bits 5..0 equal to 000011 are an interrupt-status request. It reports the status word as in R4, taken before the clear. It then clears all pending interrupt conditions, which drops `irq_o`. The lockout is left as it is.
- R6: Bit5 = 1 with bit0 = 1 clears `taddr_o` to 0. Bit5 = 1 with bit0 = 0 loads `taddr_o` from `data_i`.
- R7: Bits 5..0 equal to 100001 clear the lockout, the protect fault and all pending interrupt conditions, in addition to the clear of R6.
- R8: While `prot_sw_i` is 1, a command with `cmd_prot_i` = 0 is rejected unless it is a plain status request. Interrupt status is rejected too. A rejected command has no other effect. A reject sets the protect fault status bit.
- R9: `irq_o` is the OR of the pending terminal, word and acknowledge-failure conditions. A `term_evt_i` pulse always sets its condition. A `word_evt_i` pulse sets its condition only while `word_irq_en_o` is 1. Once set, a condition stays pending until one of the clears of R5 or R7.
- R10: An `ack_fail_i` pulse sets the lockout and raises an acknowledge-failure interrupt. While the lockout is set, further pulses raise no interrupt. The lockout stays set until the clear of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wzero_i | input | 1 | Channel indication that the word addresses a peripheral |
| strb_in_i | input | 1 | Input strobe, one clock wide |
| strb_out_i | input | 1 | Output strobe, one clock wide |
| cmd_i | input | 16 | Command word: equipment field in bits 10..7, command in bits 5..0 |
| data_i | input | 9 | Data bus value used by the terminal address load |
| eq_num_i | input | 4 | Static equipment number setting |
| prot_sw_i | input | 1 | Protect mode switch |
| cmd_prot_i | input | 1 | Channel marks the current command as protected |
| eop_i | input | 1 | End of operation status |
| dual_est_i | input | 1 | Dual mode established status |
| peer_idle_i | input | 1 | Other unit not scanning |
| peer_fail_i | input | 1 | Other unit scan failure |
| self_fail_i | input | 1 | This unit scan failure |
| busy_i | input | 1 | Busy status |
| term_evt_i | input | 1 | Terminal interrupt event pulse |
| word_evt_i | input | 1 | Periodic word interrupt event pulse |
| ack_fail_i | input | 1 | Input acknowledge failure event pulse |
| reply_o | output | 1 | Accept answer, one clock |
| reject_o | output | 1 | Reject answer, one clock |
| status_o | output | 11 | Last reported status word |
| irq_o | output | 1 | Interrupt line |
| scan_dual_o | output | 1 | Dual scan mode selected |
| scan_run_o | output | 1 | Scanning started |
| word_irq_en_o | output | 1 | Periodic word interrupt enabled |
| taddr_o | output | 9 | Terminal address register |

## Verification
Faults in the state kept by this block appear at the ports only through certain commands. A wrong protect fault, lockout or pending flag is seen on the next status request, which is at least REPLY_CYC cycles after its strobe. A stuck pending condition is seen at once on `irq_o`, and an interrupt line that fails to drop is seen one cycle after the interrupt-status reply. An error in the delay counter moves the answer off its expected edge, so the bench checks the exact answer cycle for every transaction. Mode registers and the terminal address are visible directly, and the bench compares them after every command, rejected commands included.

// File: rtl/chan_cmd_pkg.sv
package chan_cmd_pkg;

   // decoded meaning of the six command bits
   typedef struct packed {
      logic stat;      // plain status request
      logic istat;     // interrupt status request
      logic mode;      // scan mode write
      logic run;       // scan start/stop write
      logic wen;       // word interrupt gate write
      logic clr_ta;    // terminal address clear
      logic ld_ta;     // terminal address load
      logic clr_lock;  // lockout and status clear
      logic reject;    // protect violation
   } dec_t;

   localparam int ST_W     = 11;
   localparam int ST_FAULT = 10;
   localparam int ST_LOCK  = 9;
   localparam int ST_EOP   = 8;
   localparam int ST_DUAL  = 7;
   localparam int ST_PIDLE = 6;
   localparam int ST_PFAIL = 5;
   localparam int ST_SFAIL = 4;
   localparam int ST_TERM  = 3;
   localparam int ST_WORD  = 2;
   localparam int ST_BUSY  = 1;
   localparam int ST_IRQ   = 0;

   localparam logic [5:0] OP_STAT  = 6'b000001;
   localparam logic [5:0] OP_ISTAT = 6'b000011;
   localparam logic [5:0] OP_CLRLK = 6'b100001;

endpackage

// File: rtl/chan_sel.sv
module chan_sel #(
   parameter int CMD_W  = 16,
   parameter int EQ_W   = 4,
   parameter int EQ_LSB = 7,
   parameter int DATA_W = 9,
   parameter int DELAY  = 80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wzero_i,
   input  logic              strb_in_i,
   input  logic              strb_out_i,
   input  logic [CMD_W-1:0]  cmd_i,
   input  logic [EQ_W-1:0]   eq_num_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              go_o,
   output logic [5:0]        op_o,
   output logic [DATA_W-1:0] data_o
);
   localparam logic [CMD_W-1:0] USED = CMD_W'(((1 << EQ_W) - 1) << EQ_LSB) | CMD_W'(6'h3F);

   logic hit, pend;
   logic unused_bits;

   assign unused_bits = ^(cmd_i & ~USED);
   assign hit = wzero_i && (strb_in_i || strb_out_i) && (cmd_i[EQ_LSB +: EQ_W] == eq_num_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend   <= 1'b0;
         op_o   <= '0;
         data_o <= '0;
      end else if (!pend && hit) begin
         pend   <= 1'b1;
         op_o   <= cmd_i[5:0];
         data_o <= data_i;
      end else if (go_o) begin
         pend   <= 1'b0;
      end
   end

   generate
      if (DELAY > 1) begin : g_count
         localparam int CNT_W = $clog2(DELAY);
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (!pend && hit)
               cnt <= CNT_W'(DELAY - 1);
            else if (pend && cnt != '0)
               cnt <= cnt - 1'b1;
         end
         assign go_o = pend && (cnt == '0);
      end else begin : g_direct
         assign go_o = pend;
      end
   endgenerate

endmodule

// File: rtl/chan_dec.sv
module chan_dec
   import chan_cmd_pkg::*;
(
   input  logic [5:0] op_i,
   input  logic       prot_mode_i,
   input  logic       cmd_prot_i,
   output dec_t       dec_o
);
   logic plain, viol, fn;

   assign plain = (op_i == OP_STAT);
   assign viol  = prot_mode_i && !cmd_prot_i && !plain;
   assign fn    = op_i[0] && !viol;

   always_comb begin
      dec_o          = '0;
      dec_o.reject   = viol;
      dec_o.stat     = plain;
      dec_o.istat    = !viol && (op_i == OP_ISTAT);
      dec_o.mode     = fn && op_i[4];
      dec_o.run      = fn && op_i[3];
      dec_o.wen      = fn && op_i[2];
      dec_o.clr_ta   = fn && op_i[5];
      dec_o.ld_ta    = !viol && !op_i[0] && op_i[5];
      dec_o.clr_lock = !viol && (op_i == OP_CLRLK);
   end

endmodule

// File: rtl/chan_irq.sv
module chan_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic term_evt_i,
   input  logic word_evt_i,
   input  logic word_en_i,
   input  logic ack_fail_i,
   input  logic clr_irq_i,
   input  logic clr_all_i,
   input  logic set_fault_i,
   output logic term_p_o,
   output logic word_p_o,
   output logic lock_o,
   output logic fault_o,
   output logic irq_o
);
   logic ack_p, clr_p;

   assign clr_p = clr_irq_i || clr_all_i;

   // a new event wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         term_p_o <= 1'b0;
         word_p_o <= 1'b0;
         ack_p    <= 1'b0;
         lock_o   <= 1'b0;
         fault_o  <= 1'b0;
      end else begin
         term_p_o <= term_evt_i || (term_p_o && !clr_p);
         word_p_o <= (word_evt_i && word_en_i) || (word_p_o && !clr_p);
         ack_p    <= (ack_fail_i && !lock_o) || (ack_p && !clr_p);
         lock_o   <= ack_fail_i || (lock_o && !clr_all_i);
         fault_o  <= set_fault_i || (fault_o && !clr_all_i);
      end
   end

   assign irq_o = term_p_o || word_p_o || ack_p;

endmodule

// File: rtl/chan_cmd_top.sv
module chan_cmd_top
   import chan_cmd_pkg::*;
#(
   parameter int CMD_W    = 16,
   parameter int EQ_W     = 4,
   parameter int EQ_LSB   = 7,
   parameter int TADDR_W  = 9,
   parameter int CLK_PS   = 5000,
   parameter int REPLY_NS = 400
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wzero_i,
   input  logic               strb_in_i,
   input  logic               strb_out_i,
   input  logic [CMD_W-1:0]   cmd_i,
   input  logic [TADDR_W-1:0] data_i,
   input  logic [EQ_W-1:0]    eq_num_i,
   input  logic               prot_sw_i,
   input  logic               cmd_prot_i,
   input  logic               eop_i,
   input  logic               dual_est_i,
   input  logic               peer_idle_i,
   input  logic               peer_fail_i,
   input  logic               self_fail_i,
   input  logic               busy_i,
   input  logic               term_evt_i,
   input  logic               word_evt_i,
   input  logic               ack_fail_i,
   output logic               reply_o,
   output logic               reject_o,
   output logic [ST_W-1:0]    status_o,
   output logic               irq_o,
   output logic               scan_dual_o,
   output logic               scan_run_o,
   output logic               word_irq_en_o,
   output logic [TADDR_W-1:0] taddr_o
);
   localparam int REPLY_CYC = (REPLY_NS * 1000 + CLK_PS - 1) / CLK_PS;

   generate
      if (EQ_LSB + EQ_W > CMD_W || EQ_LSB < 6)
         $error("equipment field must lie above the command bits and inside the word");
      if (TADDR_W < 1 || TADDR_W > CMD_W)
         $error("terminal address width out of range");
      if (REPLY_CYC < 1)
         $error("reply delay must be at least one cycle");
   endgenerate

   logic               go;
   logic [5:0]         op_q;
   logic [TADDR_W-1:0] data_q;
   dec_t               dec;
   logic               acc;
   logic               term_p, word_p, lock_w, fault_w;
   logic [ST_W-1:0]    word_now;

   chan_sel #(
      .CMD_W(CMD_W), .EQ_W(EQ_W), .EQ_LSB(EQ_LSB),
      .DATA_W(TADDR_W), .DELAY(REPLY_CYC)
   ) u_sel (
      .clk(clk), .rst_n(rst_n), .wzero_i(wzero_i),
      .strb_in_i(strb_in_i), .strb_out_i(strb_out_i),
      .cmd_i(cmd_i), .eq_num_i(eq_num_i), .data_i(data_i),
      .go_o(go), .op_o(op_q), .data_o(data_q)
   );

   chan_dec u_dec (
      .op_i(op_q), .prot_mode_i(prot_sw_i), .cmd_prot_i(cmd_prot_i), .dec_o(dec)
   );

   assign acc = go && !dec.reject;

   chan_irq u_irq (
      .clk(clk), .rst_n(rst_n),
      .term_evt_i(term_evt_i), .word_evt_i(word_evt_i), .word_en_i(word_irq_en_o),
      .ack_fail_i(ack_fail_i),
      .clr_irq_i(acc && dec.istat), .clr_all_i(acc && dec.clr_lock),
      .set_fault_i(go && dec.reject),
      .term_p_o(term_p), .word_p_o(word_p), .lock_o(lock_w), .fault_o(fault_w),
      .irq_o(irq_o)
   );

   always_comb begin
      word_now           = '0;
      word_now[ST_FAULT] = fault_w;
      word_now[ST_LOCK]  = lock_w;
      word_now[ST_EOP]   = eop_i;
      word_now[ST_DUAL]  = dual_est_i;
      word_now[ST_PIDLE] = peer_idle_i;
      word_now[ST_PFAIL] = peer_fail_i;
      word_now[ST_SFAIL] = self_fail_i;
      word_now[ST_TERM]  = term_p;
      word_now[ST_WORD]  = word_p;
      word_now[ST_BUSY]  = busy_i;
      word_now[ST_IRQ]   = irq_o;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reply_o       <= 1'b0;
         reject_o      <= 1'b0;
         status_o      <= '0;
         scan_dual_o   <= 1'b0;
         scan_run_o    <= 1'b0;
         word_irq_en_o <= 1'b0;
         taddr_o       <= '0;
      end else begin
         reply_o  <= acc;
         reject_o <= go && dec.reject;
         if (acc && (dec.stat || dec.istat)) status_o      <= word_now;
         if (acc && dec.mode)                scan_dual_o   <= op_q[1];
         if (acc && dec.run)                 scan_run_o    <= !op_q[1];
         if (acc && dec.wen)                 word_irq_en_o <= !op_q[1];
         if (acc && dec.clr_ta)              taddr_o       <= '0;
         else if (acc && dec.ld_ta)          taddr_o       <= data_q;
      end
   end

endmodule

// File: rtl/chan_cmd_chk.sv
module chan_cmd_chk #(
   parameter int TADDR_W = 9
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reply,
   input logic               reject,
   input logic               irq,
   input logic               lock,
   input logic               fault,
   input logic               scan_run,
   input logic [TADDR_W-1:0] taddr
);
   AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
      !(reply && reject)); // R2
   AST_REJECT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      reject |-> fault); // R8
   AST_REJECT_KEEPS_TADDR: assert property (@(posedge clk) disable iff (!rst_n)
      reject |-> $stable(taddr)); // R8
   AST_IRQ_DROP_ON_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> reply); // R9
   AST_LOCK_DROP_ON_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock) |-> reply); // R10
   AST_TADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !reply |-> $stable(taddr)); // R6
   AST_RUN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !reply |-> $stable(scan_run)); // R3
endmodule

bind chan_cmd_top chan_cmd_chk #(.TADDR_W(TADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reply(reply_o), .reject(reject_o), .irq(irq_o),
   .lock(lock_w), .fault(fault_w), .scan_run(scan_run_o), .taddr(taddr_o)
);

// File: tb/chan_cmd_top_tb.sv
module chan_cmd_top_tb;
   localparam int PER_PS = 5000;
   localparam int LAT    = (400 * 1000 + PER_PS - 1) / PER_PS;
   localparam logic [3:0] EQ = 4'hA;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wzero = 0, s_in = 0, s_out = 0, prot_sw = 0, cprot = 0;
   logic [15:0] cmd = '0;
   logic [8:0]  data = '0;
   logic eop = 0, dual_est = 0, pidle = 0, pfail = 0, sfail = 0, busy = 0;
   logic term_evt = 0, word_evt = 0, ack_fail = 0;
   logic reply, reject, irq, sdual, srun, wen;
   logic [10:0] status;
   logic [8:0]  taddr;

   int n_chk = 0, n_err = 0;
   bit done = 0;
   int lat_r, wid_r;
   bit rp_r, rj_r;
   logic [10:0] st_r;

   always #2500ps clk = ~clk;

   chan_cmd_top #(.CLK_PS(PER_PS)) u_dut (
      .clk(clk), .rst_n(rst_n), .wzero_i(wzero), .strb_in_i(s_in), .strb_out_i(s_out),
      .cmd_i(cmd), .data_i(data), .eq_num_i(EQ), .prot_sw_i(prot_sw), .cmd_prot_i(cprot),
      .eop_i(eop), .dual_est_i(dual_est), .peer_idle_i(pidle), .peer_fail_i(pfail),
      .self_fail_i(sfail), .busy_i(busy), .term_evt_i(term_evt), .word_evt_i(word_evt),
      .ack_fail_i(ack_fail), .reply_o(reply), .reject_o(reject), .status_o(status),
      .irq_o(irq), .scan_dual_o(sdual), .scan_run_o(srun), .word_irq_en_o(wen),
      .taddr_o(taddr)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   // one channel transaction; sm: 0 none, 1 input strobe, 2 output strobe
   task automatic xact(input logic [5:0] c, input logic [3:0] e, input bit wz,
                       input int sm, input bit cp, input logic [8:0] d);
      @(negedge clk);
      cmd = {5'b0, e, 1'b0, c};
      wzero = wz; s_in = (sm == 1); s_out = (sm == 2); cprot = cp; data = d;
      @(negedge clk);
      s_in = 0; s_out = 0; wzero = 0;
      lat_r = -1; wid_r = 0; rp_r = 0; rj_r = 0;
      for (int k = 1; k <= LAT + 4; k++) begin
         @(negedge clk);
         if (reply || reject) begin
            wid_r++;
            if (lat_r < 0) begin
               lat_r = k; rp_r = reply; rj_r = reject; st_r = status;
            end
         end
      end
   endtask

   task automatic send(input logic [5:0] c, input bit cp, input logic [8:0] d);
      xact(c, EQ, 1'b1, 2, cp, d);
   endtask

   task automatic pulse_term();
      @(negedge clk); term_evt = 1; @(negedge clk); term_evt = 0;
   endtask
   task automatic pulse_word();
      @(negedge clk); word_evt = 1; @(negedge clk); word_evt = 0;
   endtask
   task automatic pulse_ack();
      @(negedge clk); ack_fail = 1; @(negedge clk); ack_fail = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      bit exp_dual, exp_run, exp_wen, want;
      logic [10:0] ew;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(!reply && !reject, "R2", "reset answer", {reply, reject}, 0);
      chk(!irq && taddr == 0 && status == 0, "R4", "reset state", {irq, taddr, status}, 0);
      chk(!sdual && !srun && !wen, "R3", "reset modes", {sdual, srun, wen}, 0);

      // R1 / R2: sweep of equipment field, W indication and strobe kind
      for (int e = 0; e < 16; e++)
         for (int wz = 0; wz < 2; wz++)
            for (int sm = 0; sm < 3; sm++) begin
               want = (e == EQ) && (wz == 1) && (sm != 0);
               xact(6'b000001, 4'(e), 1'(wz), sm, 1'b0, 9'h0);
               if (want) begin
                  chk(lat_r == LAT && rp_r && !rj_r, "R2", "answer cycle", lat_r, LAT);
                  chk(wid_r == 1, "R2", "answer width", wid_r, 1);
               end else
                  chk(lat_r == -1, "R1", "unselected answer", lat_r, -1);
            end

      // R2: a second strobe during the pending window is ignored
      @(negedge clk);
      cmd = {5'b0, EQ, 1'b0, 6'b000001}; wzero = 1; s_out = 1;
      @(negedge clk); s_out = 0;
      repeat (5) @(negedge clk);
      cmd = {5'b0, EQ, 1'b0, 6'b100000}; data = 9'h1FF; s_out = 1;
      @(negedge clk); s_out = 0; wzero = 0;
      repeat (LAT + 10) @(negedge clk);
      chk(taddr == 0, "R2", "strobe while pending", taddr, 0);

      // R3: sweep bits 4..1 with bit0 set
      exp_dual = 0; exp_run = 0; exp_wen = 0;
      for (int i = 0; i < 16; i++) begin
         send({1'b0, 4'(i), 1'b1}, 1'b0, 9'h0);
         if (i[3]) exp_dual = i[0];
         if (i[2]) exp_run = !i[0];
         if (i[1]) exp_wen = !i[0];
         chk(sdual == exp_dual, "R3", "dual mode", sdual, exp_dual);
         chk(srun == exp_run, "R3", "run", srun, exp_run);
         chk(wen == exp_wen, "R3", "word enable", wen, exp_wen);
      end

      // R4: status word positions
      eop = 1; dual_est = 0; pidle = 1; pfail = 0; sfail = 1; busy = 0;
      send(6'b000001, 1'b0, 9'h0);
      ew = {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
      chk(st_r == ew && status == ew, "R4", "status pattern A", st_r, ew);
      eop = 0; dual_est = 1; pidle = 0; pfail = 1; sfail = 0; busy = 1;
      send(6'b000001, 1'b0, 9'h0);
      ew = {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
      chk(st_r == ew, "R4", "status pattern B", st_r, ew);
      dual_est = 0; pfail = 0; busy = 0;

      // R9 / R5: terminal interrupt
      pulse_term();
      chk(irq == 1, "R9", "terminal raises irq", irq, 1);
      send(6'b000001, 1'b0, 9'h0);
      chk(st_r == 11'h009, "R4", "status shows terminal pending", st_r, 11'h009);
      chk(irq == 1, "R9", "plain status keeps irq", irq, 1);
      send(6'b000011, 1'b0, 9'h0);
      chk(st_r == 11'h009, "R5", "interrupt status before clear", st_r, 11'h009);
      chk(irq == 0, "R5", "interrupt status clears irq", irq, 0);

      // R9: word interrupt gated by enable
      send(6'b000111, 1'b0, 9'h0);
      pulse_word();
      chk(irq == 0, "R9", "word event while disabled", irq, 0);
      send(6'b000101, 1'b0, 9'h0);
      pulse_word();
      chk(irq == 1, "R9", "word event while enabled", irq, 1);
      send(6'b000011, 1'b0, 9'h0);
      chk(st_r == 11'h005 && irq == 0, "R5", "word pending reported then cleared", st_r, 11'h005);

      // R10 / R7: acknowledge failure lockout
      pulse_ack();
      chk(irq == 1, "R10", "ack failure irq", irq, 1);
      send(6'b000011, 1'b0, 9'h0);
      chk(st_r == 11'h201 && irq == 0, "R10", "lockout in status", st_r, 11'h201);
      pulse_ack();
      chk(irq == 0, "R10", "locked ack failure", irq, 0);
      send(6'b000001, 1'b0, 9'h0);
      chk(st_r == 11'h200, "R10", "lockout held", st_r, 11'h200);
      send(6'b100001, 1'b0, 9'h0);
      send(6'b000001, 1'b0, 9'h0);
      chk(st_r == 11'h000, "R7", "lockout cleared", st_r, 11'h000);
      pulse_ack();
      chk(irq == 1, "R10", "ack failure after clear", irq, 1);
      pulse_term();
      send(6'b100001, 1'b0, 9'h0);
      chk(irq == 0, "R7", "clear drops pending", irq, 0);

      // R6: terminal address load and clear
      send(6'b100000, 1'b0, 9'h1A5);
      chk(taddr == 9'h1A5, "R6", "load", taddr, 9'h1A5);
      send(6'b100011, 1'b0, 9'h000);
      chk(taddr == 0, "R6", "clear", taddr, 0);
      send(6'b100000, 1'b0, 9'h0AA);
      chk(taddr == 9'h0AA, "R6", "load second value", taddr, 9'h0AA);

      // R8: protect sweep of all command codes, unprotected
      exp_dual = sdual; exp_run = srun; exp_wen = wen;
      prot_sw = 1;
      for (int c = 0; c < 64; c++) begin
         send(6'(c), 1'b0, 9'h155);
         if (c == 1)
            chk(rp_r && !rj_r && lat_r == LAT, "R8", "plain status allowed", {rp_r, rj_r}, 2);
         else
            chk(rj_r && !rp_r && lat_r == LAT, "R8", "unprotected reject", {rp_r, rj_r}, 1);
         chk(taddr == 9'h0AA && sdual == exp_dual && srun == exp_run && wen == exp_wen,
             "R8", "rejected has no effect", taddr, 9'h0AA);
      end
      send(6'b000001, 1'b0, 9'h0);
      chk(st_r[10] == 1, "R8", "protect fault reported", st_r[10], 1);
      send(6'b000011, 1'b1, 9'h0);
      chk(rp_r && !rj_r, "R8", "protected interrupt status", {rp_r, rj_r}, 2);
      send(6'b100001, 1'b1, 9'h0);
      chk(rp_r && taddr == 0, "R7", "protected clear", taddr, 0);
      send(6'b000001, 1'b0, 9'h0);
      chk(st_r == 11'h000, "R7", "fault cleared", st_r, 11'h000);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule